// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block evaluates one relational predicate between two IEEE-754 operands. The operands are either both single precision or both double precision. A 4-bit predicate code selects the relation. The outcome goes into a persistent condition bit. The block also reports whether the comparison raised an invalid-operation cause. It carries no arithmetic and has no register file. A pipeline issue stage hands it one request at a time, and the branch logic reads the condition bit back.

Requests enter on a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The outcome is presented from the following cycle with `rsp_valid` high. It stays presented, unchanged, until the consumer raises `rsp_ready`. While an outcome is waiting and `rsp_ready` is low, `req_ready` is low. When `rsp_ready` is high, a new request may be accepted in the same cycle the old outcome leaves.

Top module: `fcmp_unit`

## Requirements
- R1: After reset, `rsp_valid`, `cond` and `invalid` are 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge has `rsp_valid` high after that edge, with `cond` and `invalid` already holding its outcome.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `cond` and `invalid` hold their values, and `req_ready` is 0. The outcome is dropped in the cycle after `rsp_ready` is seen high, unless a new request is accepted in that same edge.
- R4: The low three bits of `pred` form a mask: bit 0 selects unordered, bit 1 selects equal and bit 2 selects less-than. The outcome is the OR of the selected relations. Codes 0 and 8 therefore always give 0, and codes 1 and 9 give 1 exactly when either operand is a NaN.
- R5: Positive zero and negative zero compare as equal, in either order and in both formats.
- R6: For two ordered operands, a negative value is less than a positive one. Among positives, the larger exponent/fraction field is greater. Among negatives, the magnitude order is reversed. Infinities take part as the extreme values.
- R7: With `dbl`=0, only bits [31:0] of each operand are used: sign at bit 31, 8-bit exponent, 23-bit fraction. Bits [63:32] have no effect. With `dbl`=1, all 64 bits are used: sign at bit 63, 11-bit exponent, 52-bit fraction.
- R8: For codes 0 to 7, `invalid` is 1 only when an operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction, and the fraction MSB clear. A quiet NaN, with the fraction MSB set, leaves `invalid` at 0.
- R9: For codes 8 to 15, `invalid` is 1 whenever either operand is a NaN of any kind.
- R10: When a comparison raises `invalid` while `trap_en` is 1, `cond` keeps its previous value and `invalid` is still reported. Otherwise `cond` takes the new outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| dbl | input | 1 | 1 = double-precision operands, 0 = single precision in bits [31:0] |
| pred | input | 4 | Predicate code; bit 3 selects signaling NaN treatment |
| opa | input | 64 | Left-hand operand |
| opb | input | 64 | Right-hand operand |
| trap_en | input | 1 | Invalid-operation trap enabled; holds `cond` on invalid |
| rsp_valid | output | 1 | Outcome is presented |
| rsp_ready | input | 1 | Consumer takes the outcome |
| cond | output | 1 | Persistent compare condition bit |
| invalid | output | 1 | Invalid-operation cause of the last comparison |

## Verification
The bench builds the unit with its default format parameters: 8/23 bits of exponent/fraction for single precision and 11/52 for double. These values put the quiet bit at bit 22 and bit 51, and place both zeros, both infinities, signaling and quiet NaNs within reach of short directed patterns. The random operand generator draws from the same special classes and from random finite values. Some draws are copies of each other or differ only in sign, so the equal, sign-reversed and unordered paths of all 16 codes are hit in both formats. Garbage in the upper half of single-precision operands and a held-off consumer are also exercised.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic zero;
  } fp_class_t;

  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
  } fcmp_rel_t;

  typedef enum logic [3:0] {
    PR_FALSE  = 4'd0,
    PR_UNORD  = 4'd1,
    PR_EQ     = 4'd2,
    PR_UEQ    = 4'd3,
    PR_OLT    = 4'd4,
    PR_ULT    = 4'd5,
    PR_OLE    = 4'd6,
    PR_ULE    = 4'd7,
    PR_SFALSE = 4'd8,
    PR_SUNORD = 4'd9,
    PR_SEQ    = 4'd10,
    PR_SUEQ   = 4'd11,
    PR_SLT    = 4'd12,
    PR_SULT   = 4'd13,
    PR_SLE    = 4'd14,
    PR_SULE   = 4'd15
  } fcmp_pred_e;

  localparam int unsigned PRED_SIG_BIT   = 3;
  localparam int unsigned PRED_UNORD_BIT = 0;
  localparam int unsigned PRED_EQ_BIT    = 1;
  localparam int unsigned PRED_LT_BIT    = 2;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned VAL_W = EXP_W + MAN_W + 1,
  localparam int unsigned MAG_W = EXP_W + MAN_W
) (
  input  logic [VAL_W-1:0] val,
  output fp_class_t        cls,
  output logic [MAG_W-1:0] mag
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_nz;

  assign exp_f    = val[VAL_W-2 -: EXP_W];
  assign man_f    = val[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign man_nz   = |man_f;

  always_comb begin
    cls.sign = val[VAL_W-1];
    cls.nan  = exp_ones && man_nz;
    cls.snan = exp_ones && man_nz && !man_f[MAN_W-1];
    cls.zero = (exp_f == '0) && !man_nz;
  end

  assign mag = val[MAG_W-1:0];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int unsigned MAG_W = 63
) (
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output fcmp_rel_t        rel
);

  logic mag_lt;
  logic mag_eq;

  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    rel.unord = cls_a.nan || cls_b.nan;
    rel.eq    = 1'b0;
    rel.lt    = 1'b0;
    if (!rel.unord) begin
      if (cls_a.zero && cls_b.zero) begin
        rel.eq = 1'b1;
      end else if (cls_a.sign != cls_b.sign) begin
        rel.lt = cls_a.sign;
      end else if (!cls_a.sign) begin
        rel.eq = mag_eq;
        rel.lt = mag_lt;
      end else begin
        rel.eq = mag_eq;
        rel.lt = !mag_lt && !mag_eq;
      end
    end
  end

endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  fcmp_pred_e pred,
  input  fcmp_rel_t  rel,
  input  logic       snan_seen,
  output logic       outcome,
  output logic       raise_inv
);

  logic [3:0] code;
  assign code = pred;

  always_comb begin
    outcome = (code[PRED_UNORD_BIT] && rel.unord)
            | (code[PRED_EQ_BIT]    && rel.eq)
            | (code[PRED_LT_BIT]    && rel.lt);
    raise_inv = code[PRED_SIG_BIT] ? rel.unord : snan_seen;
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned SGL_EXP = 8,
  parameter int unsigned SGL_MAN = 23,
  parameter int unsigned DBL_EXP = 11,
  parameter int unsigned DBL_MAN = 52,
  localparam int unsigned SGL_W   = SGL_EXP + SGL_MAN + 1,
  localparam int unsigned DBL_W   = DBL_EXP + DBL_MAN + 1,
  localparam int unsigned SGL_MAG = SGL_EXP + SGL_MAN,
  localparam int unsigned DBL_MAG = DBL_EXP + DBL_MAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             dbl,
  input  logic [3:0]       pred,
  input  logic [DBL_W-1:0] opa,
  input  logic [DBL_W-1:0] opb,
  input  logic             trap_en,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             cond,
  output logic             invalid
);

  fp_class_t              cls_s [2];
  fp_class_t              cls_d [2];
  fp_class_t              cls   [2];
  logic [SGL_MAG-1:0]     mag_s [2];
  logic [DBL_MAG-1:0]     mag_d [2];
  logic [DBL_MAG-1:0]     mag   [2];
  logic [DBL_W-1:0]       opnd  [2];

  assign opnd[0] = opa;
  assign opnd[1] = opb;

  for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
    fcmp_classify #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_cls_s (
      .val (opnd[gi][SGL_W-1:0]),
      .cls (cls_s[gi]),
      .mag (mag_s[gi])
    );
    fcmp_classify #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_cls_d (
      .val (opnd[gi]),
      .cls (cls_d[gi]),
      .mag (mag_d[gi])
    );
    assign cls[gi] = dbl ? cls_d[gi] : cls_s[gi];
    assign mag[gi] = dbl ? mag_d[gi]
                         : {{(DBL_MAG-SGL_MAG){1'b0}}, mag_s[gi]};
  end

  fcmp_rel_t rel;
  logic      outcome;
  logic      raise_inv;

  fcmp_order #(.MAG_W(DBL_MAG)) u_order (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .rel   (rel)
  );

  fcmp_predicate u_pred (
    .pred      (fcmp_pred_e'(pred)),
    .rel       (rel),
    .snan_seen (cls[0].snan || cls[1].snan),
    .outcome   (outcome),
    .raise_inv (raise_inv)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cond      <= 1'b0;
      invalid   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      invalid   <= raise_inv;
      if (!(raise_inv && trap_en)) cond <= outcome;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int unsigned DBL_EXP = 11,
  parameter int unsigned DBL_MAN = 52,
  localparam int unsigned DBL_W  = DBL_EXP + DBL_MAN + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             dbl,
  input logic [3:0]       pred,
  input logic [DBL_W-1:0] opa,
  input logic             trap_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             cond,
  input logic             invalid
);

  logic take;
  logic a_dnan;
  assign take   = req_valid && req_ready;
  assign a_dnan = (&opa[DBL_W-2 -: DBL_EXP]) && (|opa[DBL_MAN-1:0]);

  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(cond) && $stable(invalid)));

  assert_no_take_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_never_codes_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pred[2:0] == 3'b000 && !trap_en) |=> !cond);

  assert_sig_nan_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dbl && pred[3] && a_dnan) |=> invalid);

  assert_trap_keeps_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && trap_en) |=> (!invalid || cond == $past(cond)));

endmodule

bind fcmp_unit fcmp_unit_chk #(.DBL_EXP(DBL_EXP), .DBL_MAN(DBL_MAN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dbl       (dbl),
  .pred      (pred),
  .opa       (opa),
  .trap_en   (trap_en),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .cond      (cond),
  .invalid   (invalid)
);

// File: tb/fcmp_unit_bench.sv
`timescale 1ns/1ps
module fcmp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        dbl = 1'b0;
  logic [3:0]  pred = 4'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        trap_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        cond;
  logic        invalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic model_cond = 1'b0;

  always #2 clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dbl(dbl), .pred(pred), .opa(opa), .opb(opb), .trap_en(trap_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .cond(cond), .invalid(invalid)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Key mapping: an unsigned compare of keys orders non-NaN, non-zero values.
  function automatic logic [63:0] okey(logic [63:0] x);
    return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
  endfunction

  function automatic void model(input logic d, input logic [3:0] p,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic res, output logic inv);
    logic [63:0] wa, wb;
    logic na, nb, sa, sb, za, zb, un, eq, lt;
    if (d) begin
      wa = a; wb = b;
      na = (a[62:52] == 11'h7ff) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7ff) && (b[51:0] != 0);
      sa = na && !a[51];
      sb = nb && !b[51];
    end else begin
      wa = {a[31:0], 32'h0}; wb = {b[31:0], 32'h0};
      na = (a[30:23] == 8'hff) && (a[22:0] != 0);
      nb = (b[30:23] == 8'hff) && (b[22:0] != 0);
      sa = na && !a[22];
      sb = nb && !b[22];
    end
    za = (wa[62:0] == 0);
    zb = (wb[62:0] == 0);
    un = na || nb;
    if (un) begin eq = 0; lt = 0; end
    else if (za && zb) begin eq = 1; lt = 0; end
    else begin eq = (wa == wb); lt = okey(wa) < okey(wb); end
    res = (p[0] && un) || (p[1] && eq) || (p[2] && lt);
    inv = p[3] ? un : (sa || sb);
  endfunction

  // Issue one request with the consumer ready; check the outcome one cycle later.
  task automatic run(string req, logic d, logic [3:0] p, logic [63:0] a,
                     logic [63:0] b, logic te);
    logic er, ei;
    model(d, p, a, b, er, ei);
    if (!(ei && te)) model_cond = er;
    @(posedge clk); #1;
    dbl = d; pred = p; opa = a; opb = b; trap_en = te; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R2", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    check(req, "cond", {63'd0, cond}, {63'd0, model_cond});
    check(p[3] ? "R9" : "R8", "invalid", {63'd0, invalid}, {63'd0, ei});
  endtask

  function automatic logic [63:0] rnd_op(logic d);
    logic [63:0] r;
    int k;
    r = {$urandom(), $urandom()};
    k = $urandom_range(0, 9);
    if (d) begin
      case (k)
        0: r = {r[63], 63'd0};
        1: r = {r[63], 11'h7ff, 52'd0};
        2: r = {r[63], 11'h7ff, 1'b1, r[50:0]};
        3: r = {r[63], 11'h7ff, 1'b0, r[50:1], 1'b1};
        4: r = {r[63], 11'h3ff, 52'd0};
        default: ;
      endcase
    end else begin
      case (k)
        0: r[31:0] = {r[31], 31'd0};
        1: r[31:0] = {r[31], 8'hff, 23'd0};
        2: r[31:0] = {r[31], 8'hff, 1'b1, r[21:0]};
        3: r[31:0] = {r[31], 8'hff, 1'b0, r[21:1], 1'b1};
        4: r[31:0] = {r[31], 8'h7f, 23'd0};
        default: ;
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1", "cond", {63'd0, cond}, 64'd0);
    check("R1", "invalid", {63'd0, invalid}, 64'd0);
    check("R1", "req_ready", {63'd0, req_ready}, 64'd1);

    // R5 +0 vs -0 under EQ, both formats and orders
    run("R5", 1, 4'd2, 64'h0, 64'h8000_0000_0000_0000, 0);
    run("R5", 0, 4'd10, 64'h0000_0000_8000_0000, 64'h0, 0);
    run("R5", 1, 4'd4, 64'h8000_0000_0000_0000, 64'h0, 0);
    // R6 negatives reversed: -2 < -1, -1 not < -2, -1 < +1, +inf > max
    run("R6", 1, 4'd4, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0);
    run("R6", 1, 4'd12, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 0);
    run("R6", 0, 4'd6, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 0);
    run("R6", 1, 4'd14, 64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 0);
    // R4 codes 0/8 false, 1/9 unordered
    run("R4", 1, 4'd0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0);
    run("R4", 1, 4'd1, 64'h7FF8_0000_0000_0000, 64'h0, 0);
    run("R4", 0, 4'd8, 64'h0000_0000_7FC0_0000, 64'h0, 0);
    run("R4", 0, 4'd9, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 0);
    // R7 single ignores upper bits
    run("R7", 0, 4'd2, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 0);
    run("R7", 0, 4'd4, 64'hFFFF_FFFF_4000_0000, 64'h0000_0000_3F80_0000, 0);
    // R8 quiet codes: sNaN raises, qNaN does not
    run("R8", 1, 4'd3, 64'h7FF0_0000_0000_0001, 64'h0, 0);
    run("R8", 0, 4'd7, 64'h0000_0000_7FC0_0001, 64'h0, 0);
    // R9 signaling codes: qNaN raises
    run("R9", 1, 4'd11, 64'h0, 64'hFFF8_0000_0000_0000, 0);
    // R10 trap holds cond: first set cond to 1, then invalid under trap
    run("R10", 1, 4'd2, 64'h0, 64'h0, 0);
    run("R10", 1, 4'd8, 64'h7FF8_0000_0000_0000, 64'h0, 1);
    run("R10", 1, 4'd0, 64'h7FF0_0000_0000_0001, 64'h0, 0);

    // R3 back-pressure
    model_cond = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    dbl = 1; pred = 4'd2; opa = 64'h0; opb = 64'h0; trap_en = 0; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R3", "rsp_valid held", {63'd0, rsp_valid}, 64'd1);
    check("R3", "req_ready", {63'd0, req_ready}, 64'd0);
    check("R3", "cond held", {63'd0, cond}, 64'd1);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    check("R3", "rsp_valid dropped", {63'd0, rsp_valid}, 64'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic d;
      logic [63:0] a, b;
      int m;
      d = 1'($urandom_range(0, 1));
      a = rnd_op(d);
      m = $urandom_range(0, 3);
      if (m == 0) b = a;
      else if (m == 1) b = d ? (a ^ 64'h8000_0000_0000_0000) : (a ^ 64'h8000_0000);
      else b = rnd_op(d);
      run("R4", d, 4'($urandom_range(0, 15)), a, b, 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule